// File: doc/BRIEF.md
# Cascaded Interrupt Controller

This block gathers up to 32 interrupt requests and presents them to a processor on two lines: a normal interrupt line and a fast interrupt line. Each request sets a bit in a source-pending register. A mask register decides which pending sources may compete. A selection stage takes the lowest-numbered eligible source, latches it as a single bit in an interrupt-pending register, and reports its index in an offset register. That choice is held until software clears it. A mode register can steer exactly one source to the fast line instead.

Four source positions are not wired to direct inputs. Each of them is the OR of a group of sub-sources. The sub-sources have their own pending and mask registers, so one peripheral with several reasons to interrupt shares a single parent position. Two positions are reserved and never raise a request.

Software reaches the registers through plain write and read strobes on a 3-bit word address. There is no handshake on this bus: a write takes effect at the clock edge where it is strobed, and read data appears one cycle after the read strobe. Request inputs are level signals sampled on every clock edge, so they need no flow control.

Top module: `intc_cascade`

## Requirements
- R1: A high direct request input sets its source-pending bit at the next clock edge. Inputs at positions 6 and 24 (reserved) and at the four parent positions 16, 17, 18 and 19 never set a bit.
- R2: Writing to source-pending (address 0) or interrupt-pending (address 3) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R3: A 1 in the mask register (address 2) keeps that source out of selection. The mask register resets to all ones.
- R4: When interrupt-pending is empty, the lowest-numbered source that is pending, unmasked and not routed to the fast line is latched as the only set bit of interrupt-pending (address 3). The offset register (address 4) then holds its index, and it reads 0 when nothing is latched.
- R5: irq_o is high exactly while interrupt-pending is non-zero. A latched bit stays in place even when a lower-numbered source becomes pending, until software clears it.
- R6: Sub-sources 0-2 drive parent 16, 3-5 drive parent 17, 6-8 drive parent 18 and 9-10 drive parent 19. A parent requests while any sub-source in its group is pending and not sub-masked.
- R7: A high sub-request input sets its sub-pending bit (address 5) at the next edge. Writing 1 to that bit clears it and writing 0 has no effect. The sub-mask register (address 6) resets to all ones.
- R8: A write to the mode register (address 1) keeps only the lowest set bit of the written value, so the register is always zero or one-hot. fiq_o is high while the source it selects is pending and unmasked.
- R9: A source selected by the mode register is never latched into interrupt-pending. Once the mode register is cleared, that source competes normally.
- R10: All registers reset to zero except the two mask registers. rd_data_o shows the addressed register one cycle after rd_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word address |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid the cycle after rd_en_i |
| src_i | input | 32 | Direct request levels, one per source position |
| sub_i | input | 11 | Sub-source request levels |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
The assertions assume that reset is held low from time zero until the first edges have passed. They also assume that the mode register is never pointed at a source that is already latched in interrupt-pending: the fast-line exclusion is checked only at the moment of selection, so a later mode change is outside what it covers. The stimulus drives request inputs and bus strobes on the falling edge and performs one bus operation at a time. It changes the mode register only while nothing is latched, and it raises all the sources of a case under a full mask before unmasking them, so the arbitration sees the whole set at once.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned AW   = 3;
  localparam int unsigned NGRP = 4;

  typedef enum logic [AW-1:0] {
    A_SRCPND = 3'd0,
    A_MODE   = 3'd1,
    A_MASK   = 3'd2,
    A_INTPND = 3'd3,
    A_OFFSET = 3'd4,
    A_SUBPND = 3'd5,
    A_SUBMSK = 3'd6
  } regsel_e;
endpackage

// File: rtl/intc_subcascade.sv
module intc_subcascade
  import intc_pkg::*;
#(
  parameter int unsigned NSUB = 11,
  parameter int unsigned GRP_FIRST [NGRP] = '{0, 3, 6, 9},
  parameter int unsigned GRP_LAST  [NGRP] = '{2, 5, 8, 10}
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSUB-1:0] sub_i,
  input  logic [NSUB-1:0] clr_i,
  input  logic            msk_we_i,
  input  logic [NSUB-1:0] msk_wdata_i,
  output logic [NSUB-1:0] subpend_o,
  output logic [NSUB-1:0] submask_o,
  output logic [NGRP-1:0] grp_req_o
);
  logic [NSUB-1:0] pend_q, msk_q, live;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pend_q <= '0;
      msk_q  <= '1;
    end else begin
      // level request wins over a clear in the same cycle
      pend_q <= (pend_q & ~clr_i) | sub_i;
      if (msk_we_i) msk_q <= msk_wdata_i;
    end
  end

  assign live = pend_q & ~msk_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_req_o[g] = |live[GRP_LAST[g]:GRP_FIRST[g]];
  end

  assign subpend_o = pend_q;
  assign submask_o = msk_q;
endmodule

// File: rtl/intc_srcpend.sv
module intc_srcpend
  import intc_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned RSV_A = 6,
  parameter int unsigned RSV_B = 24,
  parameter int unsigned PARENT_POS [NGRP] = '{16, 17, 18, 19}
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NGRP-1:0] grp_req_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] srcpend_o
);
  function automatic int parent_of(int unsigned b);
    for (int g = 0; g < int'(NGRP); g++)
      if (PARENT_POS[g] == b) return g;
    return -1;
  endfunction

  logic [NSRC-1:0] req, pend_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    localparam int PIDX = parent_of(i);
    if (i == RSV_A || i == RSV_B) begin : g_rsv
      assign req[i] = 1'b0;
    end else if (PIDX >= 0) begin : g_par
      assign req[i] = grp_req_i[PIDX];
    end else begin : g_dir
      assign req[i] = src_i[i];
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | req;
  end

  assign srcpend_o = pend_q;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int unsigned NSRC = 32,
  localparam int unsigned OW  = $clog2(NSRC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] srcpend_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic [NSRC-1:0] mode_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] intpend_o,
  output logic [OW-1:0]   offset_o
);
  logic [NSRC-1:0] cand, pick, held_q, held_nxt;
  logic [OW-1:0]   idx, off_q;

  assign cand = srcpend_i & ~mask_i & ~mode_i;
  assign pick = cand & (~cand + {{(NSRC-1){1'b0}}, 1'b1});

  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (cand[i]) idx = OW'(i);
  end

  assign held_nxt = held_q & ~clr_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      held_q <= '0;
      off_q  <= '0;
    end else if (|held_q) begin
      held_q <= held_nxt;
      if (held_nxt == '0) off_q <= '0;
    end else if (|cand) begin
      held_q <= pick;
      off_q  <= idx;
    end
  end

  assign intpend_o = held_q;
  assign offset_o  = off_q;
endmodule

// File: rtl/intc_cascade.sv
module intc_cascade
  import intc_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSUB  = 11,
  parameter int unsigned RSV_A = 6,
  parameter int unsigned RSV_B = 24,
  parameter int unsigned PARENT_POS [NGRP] = '{16, 17, 18, 19},
  parameter int unsigned GRP_FIRST  [NGRP] = '{0, 3, 6, 9},
  parameter int unsigned GRP_LAST   [NGRP] = '{2, 5, 8, 10}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic [NSRC-1:0]   src_i,
  input  logic [NSUB-1:0]   sub_i,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int unsigned OW = $clog2(NSRC);

  logic [NSRC-1:0] srcpend_q, intpend_q, mask_q, mode_q, wv;
  logic [NSUB-1:0] subpend_q, submask_q;
  logic [NGRP-1:0] grp_req;
  logic [OW-1:0]   offset_q;
  logic [DW-1:0]   rd_mux, rd_q;

  function automatic logic hit(logic en, logic [AW-1:0] a, regsel_e r);
    return en && (a == r);
  endfunction

  assign wv = wr_data_i[NSRC-1:0];

  intc_subcascade #(
    .NSUB(NSUB), .GRP_FIRST(GRP_FIRST), .GRP_LAST(GRP_LAST)
  ) u_sub (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sub_i       (sub_i),
    .clr_i       (hit(wr_en_i, addr_i, A_SUBPND) ? wr_data_i[NSUB-1:0] : '0),
    .msk_we_i    (hit(wr_en_i, addr_i, A_SUBMSK)),
    .msk_wdata_i (wr_data_i[NSUB-1:0]),
    .subpend_o   (subpend_q),
    .submask_o   (submask_q),
    .grp_req_o   (grp_req)
  );

  intc_srcpend #(
    .NSRC(NSRC), .RSV_A(RSV_A), .RSV_B(RSV_B), .PARENT_POS(PARENT_POS)
  ) u_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (src_i),
    .grp_req_i (grp_req),
    .clr_i     (hit(wr_en_i, addr_i, A_SRCPND) ? wv : '0),
    .srcpend_o (srcpend_q)
  );

  intc_arbiter #(.NSRC(NSRC)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srcpend_i (srcpend_q),
    .mask_i    (mask_q),
    .mode_i    (mode_q),
    .clr_i     (hit(wr_en_i, addr_i, A_INTPND) ? wv : '0),
    .intpend_o (intpend_q),
    .offset_o  (offset_q)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mask_q <= '1;
      mode_q <= '0;
      rd_q   <= '0;
    end else begin
      if (hit(wr_en_i, addr_i, A_MASK)) mask_q <= wv;
      // keep only the lowest set bit so at most one source is diverted
      if (hit(wr_en_i, addr_i, A_MODE))
        mode_q <= wv & (~wv + {{(NSRC-1){1'b0}}, 1'b1});
      if (rd_en_i) rd_q <= rd_mux;
    end
  end

  always_comb begin
    case (addr_i)
      A_SRCPND: rd_mux = DW'(srcpend_q);
      A_MODE:   rd_mux = DW'(mode_q);
      A_MASK:   rd_mux = DW'(mask_q);
      A_INTPND: rd_mux = DW'(intpend_q);
      A_OFFSET: rd_mux = DW'(offset_q);
      A_SUBPND: rd_mux = DW'(subpend_q);
      A_SUBMSK: rd_mux = DW'(submask_q);
      default:  rd_mux = '0;
    endcase
  end

  assign rd_data_o = rd_q;
  assign irq_o     = |intpend_q;
  assign fiq_o     = |(srcpend_q & mode_q & ~mask_q);
endmodule

// File: rtl/intc_cascade_chk.sv
module intc_cascade_chk
  import intc_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSUB  = 11,
  parameter int unsigned RSV_A = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [AW-1:0]   addr_i,
  input logic [DW-1:0]   wr_data_i,
  input logic [NSRC-1:0] src_i,
  input logic [NSUB-1:0] sub_i,
  input logic            irq_o,
  input logic [NSRC-1:0] intpend_q,
  input logic [NSRC-1:0] mode_q,
  input logic [NSRC-1:0] mask_q,
  input logic [NSUB-1:0] subpend_q,
  input logic [NSRC-1:0] srcpend_q
);
  // R4
  intpend_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(intpend_q));

  // R5
  intpend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|intpend_q) && !(wr_en_i && addr_i == A_INTPND &&
      |(wr_data_i[NSRC-1:0] & intpend_q))) |=> $stable(intpend_q));

  // R3
  mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ((intpend_q & $past(mask_q)) == '0));

  // R9
  fiq_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ((intpend_q & $past(mode_q)) == '0));

  // R8
  mode_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mode_q));

  // R7
  sub_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sub_i) |=> ((subpend_q & $past(sub_i)) == $past(sub_i)));

  // R1
  rsv_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_i[RSV_A] |=> !srcpend_q[RSV_A]);
endmodule

bind intc_cascade intc_cascade_chk #(
  .NSRC(NSRC), .NSUB(NSUB), .RSV_A(RSV_A)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wr_data_i (wr_data_i),
  .src_i     (src_i),
  .sub_i     (sub_i),
  .irq_o     (irq_o),
  .intpend_q (intpend_q),
  .mode_q    (mode_q),
  .mask_q    (mask_q),
  .subpend_q (subpend_q),
  .srcpend_q (srcpend_q)
);

// File: tb/intc_cascade_tb_top.sv
`timescale 1ns/1ps
module intc_cascade_tb_top;
  import intc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] src = '0;
  logic [10:0] sub = '0;
  logic        irq, fiq;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  intc_cascade dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
    .src_i(src), .sub_i(sub), .irq_o(irq), .fiq_o(fiq)
  );

  typedef struct packed {
    logic [31:0] s;
    logic [10:0] sb;
    logic [31:0] msk;
    logic [10:0] smsk;
    logic [4:0]  off;
    logic        req;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{32'h0000_0020, 11'h000, 32'h0000_0000, 11'h7FF, 5'd5,  1'b1},
    '{32'h0000_0208, 11'h000, 32'h0000_0000, 11'h7FF, 5'd3,  1'b1},
    '{32'h0000_0208, 11'h000, 32'h0000_0008, 11'h7FF, 5'd9,  1'b1},
    '{32'h0000_0040, 11'h000, 32'h0000_0000, 11'h7FF, 5'd0,  1'b0},
    '{32'h4100_0000, 11'h000, 32'h0000_0000, 11'h7FF, 5'd30, 1'b1},
    '{32'h0000_0000, 11'h010, 32'h0000_0000, 11'h000, 5'd17, 1'b1},
    '{32'h0000_0000, 11'h010, 32'h0000_0000, 11'h010, 5'd0,  1'b0},
    '{32'h0010_0000, 11'h400, 32'h0000_0000, 11'h000, 5'd19, 1'b1},
    '{32'h0001_0000, 11'h000, 32'h0000_0000, 11'h000, 5'd0,  1'b0},
    '{32'hFFFF_FFFF, 11'h000, 32'hFFFF_FFFF, 11'h000, 5'd0,  1'b0},
    '{32'h8000_0000, 11'h000, 32'h0000_0000, 11'h7FF, 5'd31, 1'b1},
    '{32'h0000_0000, 11'h101, 32'h0000_0000, 11'h000, 5'd16, 1'b1}
  };

  // expected source-pending from R1 and R6
  function automatic logic [31:0] exp_src(logic [31:0] s, logic [10:0] sb,
                                          logic [10:0] sm);
    logic [10:0] live;
    logic [31:0] r;
    live = sb & ~sm;
    r = s;
    r[6] = 1'b0;
    r[24] = 1'b0;
    r[16] = |live[2:0];
    r[17] = |live[5:3];
    r[18] = |live[8:6];
    r[19] = |live[10:9];
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(regsel_e a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(regsel_e a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(logic [31:0] s, logic [10:0] sb);
    @(negedge clk);
    src = s; sub = sb;
    @(negedge clk);
    src = '0; sub = '0;
  endtask

  task automatic clear_all();
    wr(A_SUBPND, 32'h0000_07FF);
    wr(A_SRCPND, 32'hFFFF_FFFF);
    wr(A_INTPND, 32'hFFFF_FFFF);
    idle(2);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // reset state, R10 R3 R7
    check("R10 irq_o after reset", 32'(irq), 32'h0);
    check("R10 fiq_o after reset", 32'(fiq), 32'h0);
    rd(A_MASK, v);   check("R3 mask reset", v, 32'hFFFF_FFFF);
    rd(A_SUBMSK, v); check("R7 sub-mask reset", v, 32'h0000_07FF);
    rd(A_OFFSET, v); check("R10 offset reset", v, 32'h0);
    rd(A_MODE, v);   check("R10 mode reset", v, 32'h0);

    // vector table: R1 R3 R4 R6
    for (int k = 0; k < 12; k++) begin
      wr(A_MASK, 32'hFFFF_FFFF);
      wr(A_SUBMSK, {21'h0, VECS[k].smsk});
      pulse(VECS[k].s, VECS[k].sb);
      idle(3);
      wr(A_MASK, VECS[k].msk);
      idle(3);
      rd(A_SRCPND, v);
      check($sformatf("R1 R6 vector %0d source-pending", k), v,
            exp_src(VECS[k].s, VECS[k].sb, VECS[k].smsk));
      check($sformatf("R5 vector %0d irq_o", k), 32'(irq), 32'(VECS[k].req));
      rd(A_OFFSET, v);
      check($sformatf("R4 vector %0d offset", k), v, 32'(VECS[k].off));
      rd(A_INTPND, v);
      check($sformatf("R4 R3 vector %0d interrupt-pending", k), v,
            VECS[k].req ? (32'h1 << VECS[k].off) : 32'h0);
      clear_all();
    end

    // R5: latched source held while a lower one arrives
    wr(A_MASK, 32'h0);
    pulse(32'h0000_0400, 11'h0);
    idle(3);
    pulse(32'h0000_0004, 11'h0);
    idle(3);
    rd(A_OFFSET, v); check("R5 hold offset", v, 32'd10);
    check("R5 hold irq_o", 32'(irq), 32'h1);
    wr(A_SRCPND, 32'h0000_0400);
    wr(A_INTPND, 32'h0000_0400);
    idle(3);
    rd(A_OFFSET, v); check("R5 next after clear", v, 32'd2);
    clear_all();
    check("R5 irq_o low after clear", 32'(irq), 32'h0);

    // R2: writing zeros leaves pending bits
    wr(A_MASK, 32'hFFFF_FFFF);
    pulse(32'h0000_1000, 11'h0);
    wr(A_SRCPND, 32'h0);
    rd(A_SRCPND, v); check("R2 write zero keeps bit", v, 32'h0000_1000);
    wr(A_SRCPND, 32'h0000_1000);
    rd(A_SRCPND, v); check("R2 write one clears bit", v, 32'h0);

    // R8: mode keeps lowest bit
    wr(A_MODE, 32'h0000_0030);
    rd(A_MODE, v); check("R8 mode one-hot", v, 32'h0000_0010);
    wr(A_MODE, 32'h0);

    // R8 R9: diverted source
    wr(A_MASK, 32'h0);
    wr(A_MODE, 32'h0000_0080);
    pulse(32'h0000_0080, 11'h0);
    idle(3);
    check("R8 fiq_o raised", 32'(fiq), 32'h1);
    check("R9 irq_o quiet", 32'(irq), 32'h0);
    rd(A_INTPND, v); check("R9 interrupt-pending empty", v, 32'h0);
    wr(A_MODE, 32'h0);
    idle(3);
    check("R9 fiq_o dropped", 32'(fiq), 32'h0);
    rd(A_OFFSET, v); check("R9 source competes after mode clear", v, 32'd7);
    clear_all();

    // R7 R6: sub-pending clear and masked parent
    wr(A_SUBMSK, 32'h0000_07FF);
    pulse(32'h0, 11'h004);
    rd(A_SUBPND, v); check("R7 sub-pending set", v, 32'h0000_0004);
    rd(A_SRCPND, v); check("R6 masked sub keeps parent quiet", v, 32'h0);
    wr(A_SUBPND, 32'h0);
    rd(A_SUBPND, v); check("R7 write zero keeps sub bit", v, 32'h0000_0004);
    wr(A_SUBPND, 32'h0000_0004);
    rd(A_SUBPND, v); check("R7 write one clears sub bit", v, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule